// File: doc/BRIEF.md
# Paced Byte-Stream DMA Engine

This block streams bytes from a circular buffer RAM to a downstream consumer at a programmable pace. Software loads a 16-bit transfer count as two byte registers, sets a start address, sets an output-enable bit and then pulses a trigger. From then on the block presents one byte per deadline on a valid/ready output. Deadlines are spaced by a period equal to a fixed base step of four clocks times a programmable pacing multiple. Each deadline is set from the previous one, not from the moment the consumer took the byte. A consumer that is late therefore does not push back the rest of the schedule.

The count registers work the way a hardware down-counter split into two bytes works. Each accepted byte decrements the low byte, and a wrap of the low byte to 0xFF borrows from the high byte. A transfer moves count+1 bytes and ends when the count passes below zero. The buffer is a synchronous RAM inside the block, filled through a separate write port. Reads wrap around the buffer. Clearing output-enable pauses a running transfer and keeps its position, and a later trigger resumes it.

Top module: `dma_byte_pacer`

## Requirements
- R1: After reset, `out_valid` and `xfer_done` are 0, `data_busy_n` is 1 and the pacing multiple is 6, so the byte period is 24 clocks until the multiple is rewritten.
- R2: A `trig` pulse while output-enable (control register, select 2, bit 0) is 1 starts a transfer. From the next cycle `data_busy_n` reads 0 and the first byte is valid.
- R3: A `trig` pulse while output-enable is 0 is ignored. No byte is offered, `data_busy_n` stays 1, and the count and address registers keep their values for a later transfer.
- R4: The byte period is 4 times the pacing multiple (select 3). Byte n+1 becomes valid exactly one period after the cycle in which byte n first became eligible. If that deadline has already passed when byte n is accepted, byte n+1 is valid in the next cycle.
- R5: While a valid byte is refused (`out_ready` low), `out_valid` stays high and `out_data` stays stable. The address and count do not advance.
- R6: Bytes leave in increasing buffer address order from the start address (select 4). The address wraps modulo the buffer depth (64 by default).
- R7: The count is a low byte (select 0) and a high byte (select 1). Each accepted byte decrements the low byte, and a wrap of the low byte to 0xFF also decrements the high byte. A transfer moves count+1 bytes.
- R8: A pacing multiple written mid-transfer leaves the deadline already scheduled unchanged and sets the spacing of every later byte.
- R9: The cycle after the final byte is accepted, `xfer_done` pulses for exactly one cycle, `data_busy_n` returns to 1 and `out_valid` is 0.
- R10: Clearing output-enable mid-transfer drops `out_valid` and sets `data_busy_n` to 1 at once, with no `xfer_done`. A later trigger with output-enable set resumes from the remaining bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 count low, 1 count high, 2 control, 3 multiple, 4 start address |
| wr_data | input | 8 | Register write data |
| trig | input | 1 | Transfer trigger strobe |
| fill_we | input | 1 | Buffer fill write enable |
| fill_addr | input | ADDR_W | Buffer fill address |
| fill_data | input | 8 | Buffer fill data |
| out_data | output | 8 | Byte offered to the consumer |
| out_valid | output | 1 | Byte is offered |
| out_ready | input | 1 | Consumer accepts the byte |
| data_busy_n | output | 1 | Active-low transfer busy status |
| xfer_done | output | 1 | One-cycle pulse at transfer end |

## Verification
The bound checker covers the local rules on every cycle. It checks that a refused byte stays valid and unchanged, that an enabled trigger brings up busy and the first byte, and that an ignored trigger leaves the block idle. It also checks that the done pulse is a single cycle, follows an accepted byte and leaves the output idle. Deadline spacing, the effect of a multiple changed mid-transfer, the borrow across count bytes, address wrap, and pause and resume can only be shown by the bench. There a scoreboard predicts every byte and every eligibility cycle from its own model of the schedule.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;

  typedef enum logic [2:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_MULT   = 3'd3,
    SEL_ADDR   = 3'd4
  } reg_sel_e;

  localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dma_pace_timer.sv
// Tracks the signed distance to the next byte deadline.
// Zero or negative means the deadline has been reached.
module dma_pace_timer #(
  parameter int PERIOD_W = 11,
  parameter int LEAD_W   = PERIOD_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                run,
  input  logic                accept,
  input  logic [PERIOD_W-1:0] period,
  output logic                due
);

  localparam logic signed [LEAD_W-1:0] LEAD_MIN = {1'b1, {(LEAD_W-1){1'b0}}};
  localparam logic signed [LEAD_W-1:0] LEAD_ONE = LEAD_W'(1);
  localparam int PAD_W = LEAD_W - PERIOD_W;

  logic signed [LEAD_W-1:0] lead_q;
  logic signed [LEAD_W-1:0] lead_d;
  logic signed [LEAD_W-1:0] period_s;
  logic                     lead_en;

  assign period_s = $signed({{PAD_W{1'b0}}, period});
  assign lead_en  = start | run;

  always_comb begin
    lead_d = lead_q;
    if (start) begin
      lead_d = '0;
    end else if (accept) begin
      // next deadline = previous deadline + period
      lead_d = lead_q - LEAD_ONE + period_s;
    end else if (lead_q != LEAD_MIN) begin
      lead_d = lead_q - LEAD_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= '0;
    end else if (lead_en) begin
      lead_q <= lead_d;
    end
  end

  assign due = lead_q[LEAD_W-1] | (lead_q == '0);

endmodule

// File: rtl/dma_xfer_count.sv
// Split byte down-counter: low byte borrows into high byte.
module dma_xfer_count (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  input  logic       step,
  output logic       at_zero
);

  logic [7:0] lo_q, lo_d;
  logic [7:0] hi_q, hi_d;
  logic       lo_en, hi_en;
  logic       borrow;

  assign borrow = step & (lo_q == 8'h00);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (step) begin
      lo_d = lo_q - 8'd1;
    end
    if (borrow) begin
      hi_d = hi_q - 8'd1;
    end
    if (wr_lo) begin
      lo_d = wr_data;
    end
    if (wr_hi) begin
      hi_d = wr_data;
    end
  end

  assign lo_en = step | wr_lo;
  assign hi_en = borrow | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  assign at_zero = (lo_q == 8'h00) & (hi_q == 8'h00);

endmodule

// File: rtl/dma_addr_ptr.sv
// Buffer read pointer; exposes next value so the RAM output tracks it.
module dma_addr_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_next
);

  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_en;

  always_comb begin
    ptr_next = ptr_q;
    if (wr) begin
      ptr_next = wr_val;
    end else if (step) begin
      ptr_next = ptr_q + ADDR_W'(1);   // wraps at buffer depth
    end
  end

  assign ptr_en = wr | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_next;
    end
  end

endmodule

// File: rtl/dma_byte_pacer.sv
module dma_byte_pacer
  import dma_pacer_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int STEP     = 4,
  parameter int MULT_W   = 8,
  parameter int MULT_RST = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              trig,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              data_busy_n,
  output logic              xfer_done
);

  localparam int PERIOD_W = MULT_W + $clog2(STEP + 1);
  localparam int LEAD_W   = PERIOD_W + 2;
  localparam logic [PERIOD_W-1:0] STEP_V = PERIOD_W'(STEP);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // register write decode
  logic wr_lo, wr_hi, wr_ctrl, wr_mult, wr_addr;

  assign wr_lo   = wr_en & (wr_sel == SEL_CNT_LO);
  assign wr_hi   = wr_en & (wr_sel == SEL_CNT_HI);
  assign wr_ctrl = wr_en & (wr_sel == SEL_CTRL);
  assign wr_mult = wr_en & (wr_sel == SEL_MULT);
  assign wr_addr = wr_en & (wr_sel == SEL_ADDR);

  // control and pacing multiple registers
  logic              en_q;
  logic [MULT_W-1:0] mult_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= wr_data[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mult_q <= MULT_W'(MULT_RST);
    end else if (wr_mult) begin
      mult_q <= wr_data[MULT_W-1:0];
    end
  end

  logic [PERIOD_W-1:0] period;
  assign period = PERIOD_W'(mult_q) * STEP_V;

  // transfer state
  logic active_q, active_d;
  logic done_q, done_d;
  logic start, run, accept, finish, due, at_zero;
  logic [ADDR_W-1:0] rd_addr;

  assign start  = trig & en_q;
  assign run    = active_q & en_q;
  assign accept = out_valid & out_ready;
  assign finish = accept & at_zero;

  always_comb begin
    active_d = active_q;
    if (start) begin
      active_d = 1'b1;
    end else if (finish || !en_q) begin
      active_d = 1'b0;
    end
    done_d = finish & ~start;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  dma_pace_timer #(
    .PERIOD_W (PERIOD_W),
    .LEAD_W   (LEAD_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .run    (run),
    .accept (accept),
    .period (period),
    .due    (due)
  );

  dma_xfer_count u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .step    (accept),
    .at_zero (at_zero)
  );

  dma_addr_ptr #(
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (wr_addr),
    .wr_val   (wr_data[ADDR_W-1:0]),
    .step     (accept),
    .ptr_next (rd_addr)
  );

  dma_buf_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (8)
  ) u_ram (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fill_addr),
    .wdata (fill_data),
    .raddr (rd_addr),
    .rdata (out_data)
  );

  assign out_valid   = run & due;
  assign data_busy_n = ~run;
  assign xfer_done   = done_q;

endmodule

// File: rtl/dma_byte_pacer_chk.sv
module dma_byte_pacer_chk
  import dma_pacer_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       wr_bit0,
  input logic       trig,
  input logic       fill_we,
  input logic       en_q,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       data_busy_n,
  input logic       xfer_done
);

  logic quiet_cfg;
  assign quiet_cfg = ~wr_en;

  assert_hold_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && quiet_cfg && !fill_we && !$past(fill_we))
      |=> (out_valid && $stable(out_data)));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && en_q && !(wr_en && wr_sel == SEL_CTRL))
      |=> (!data_busy_n && out_valid));

  assert_ignore_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !en_q && data_busy_n && !(wr_en && wr_sel == SEL_CTRL && wr_bit0))
      |=> (data_busy_n && !out_valid));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (data_busy_n && !out_valid));

  assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(out_valid && out_ready));

  assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !data_busy_n);

endmodule

bind dma_byte_pacer dma_byte_pacer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_bit0     (wr_data[0]),
  .trig        (trig),
  .fill_we     (fill_we),
  .en_q        (en_q),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .data_busy_n (data_busy_n),
  .xfer_done   (xfer_done)
);

// File: tb/dma_byte_pacer_bench.sv
module dma_byte_pacer_bench;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_sel;
  logic [7:0]    wr_data;
  logic          trig;
  logic          fill_we;
  logic [AW-1:0] fill_addr;
  logic [7:0]    fill_data;
  logic [7:0]    out_data;
  logic          out_valid;
  logic          out_ready;
  logic          data_busy_n;
  logic          xfer_done;

  dma_byte_pacer u_dma_byte_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .trig        (trig),
    .fill_we     (fill_we),
    .fill_addr   (fill_addr),
    .fill_data   (fill_data),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .data_busy_n (data_busy_n),
    .xfer_done   (xfer_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;
  bit         mon_on = 0;
  bit         armed = 0;
  int         deadline = 0;
  int         remaining = 0;
  int         done_at = -1;
  int         done_cnt = 0;
  int         model_mult = 6;   // R1 reset multiple
  int         rdy_mode = 1;
  bit         rdy_hold = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] mem_model [DEPTH];
  logic [7:0] exp_q [$];
  bit         stalled = 0;
  logic [7:0] held = 0;
  bit         exp_v;
  logic [7:0] exp_b;
  bit         finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // consumer ready driver
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      1: out_ready = 1'b1;
      2: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] & (lfsr[3] | lfsr[5]);
      end
      default: out_ready = rdy_hold;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      exp_v = armed && (cyc >= deadline);
      check(out_valid === exp_v, "R4", "valid vs deadline", int'(out_valid), int'(exp_v));
      check(data_busy_n === !armed, "R2", "busy_n", int'(data_busy_n), int'(!armed));
      check(xfer_done === (cyc == done_at), "R9", "done pulse", int'(xfer_done), int'(cyc == done_at));
      if (xfer_done) done_cnt++;
      if (stalled && out_valid)
        check(out_data === held, "R5", "held byte", int'(out_data), int'(held));
      stalled = out_valid && !out_ready;
      held    = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected byte", int'(out_data), -1);
        end else begin
          exp_b = exp_q.pop_front();
          check(out_data === exp_b, "R6", "byte data", int'(out_data), int'(exp_b));
        end
        remaining--;
        deadline += 4 * model_mult;   // R4, R8: schedule from previous deadline
        if (remaining == 0) begin
          armed   = 0;
          done_at = cyc + 1;
        end
      end
    end
  end

  task automatic wr_reg(input int sel, input int data);
    wr_en   = 1'b1;
    wr_sel  = 3'(sel);
    wr_data = 8'(data);
    @(posedge clk);
    if (sel == 3) model_mult = data & 8'hFF;
    if (sel == 2 && (data & 1) == 0) armed = 0;
    #1;
    wr_en = 1'b0;
  endtask

  task automatic fire(input bit expect_start);
    trig = 1'b1;
    @(posedge clk);
    if (expect_start) begin
      armed    = 1;
      deadline = cyc + 1;
    end
    #1;
    trig = 1'b0;
  endtask

  task automatic setup_xfer(input int addr, input int count);
    wr_reg(4, addr);
    wr_reg(0, count & 8'hFF);
    wr_reg(1, (count >> 8) & 8'hFF);
  endtask

  task automatic arm(input int addr, input int count);
    for (int i = 0; i <= count; i++) exp_q.push_back(mem_model[(addr + i) % DEPTH]);
    remaining = count + 1;
    fire(1'b1);
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (armed);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic end_xfer(input int done_before, input string tag);
    check(exp_q.size() == 0, "R7", {tag, " all bytes moved"}, exp_q.size(), 0);
    check(done_cnt == done_before + 1, "R9", {tag, " one done pulse"}, done_cnt, done_before + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    int d0;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; trig = 0;
    fill_we = 0; fill_addr = 0; fill_data = 0; out_ready = 1;
    repeat (4) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "reset valid", int'(out_valid), 0);
    check(data_busy_n === 1'b1, "R1", "reset busy_n", int'(data_busy_n), 1);
    check(xfer_done === 1'b0, "R1", "reset done", int'(xfer_done), 0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    mon_on = 1;

    for (int i = 0; i < DEPTH; i++) begin
      mem_model[i] = 8'((i * 37 + 11) & 8'hFF);
      fill_we = 1; fill_addr = AW'(i); fill_data = mem_model[i];
      @(posedge clk); #1;
    end
    fill_we = 0;

    wr_reg(2, 1);

    // R1: default multiple 6 -> 24-clock spacing
    d0 = done_cnt;
    setup_xfer(5, 3);
    arm(5, 3);
    wait_idle();
    end_xfer(d0, "default pace");

    // R7 borrow + R6 wrap, period 4
    wr_reg(3, 1);
    d0 = done_cnt;
    setup_xfer(60, 16'h0102);
    arm(60, 16'h0102);
    wait_idle();
    end_xfer(d0, "borrow");

    // R5 / R4 random back-pressure
    wr_reg(3, 2);
    rdy_mode = 2;
    d0 = done_cnt;
    setup_xfer(10, 40);
    arm(10, 40);
    wait_idle();
    end_xfer(d0, "backpressure");
    rdy_mode = 1;

    // R8 multiple change mid-transfer
    wr_reg(3, 2);
    d0 = done_cnt;
    setup_xfer(0, 11);
    arm(0, 11);
    repeat (25) @(posedge clk);
    #1;
    wr_reg(3, 5);
    wait_idle();
    end_xfer(d0, "R8 repace");

    // R3 ignored trigger, counters kept
    wr_reg(2, 0);
    setup_xfer(20, 2);
    fire(1'b0);
    repeat (6) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R3", "no byte after ignored trigger", int'(out_valid), 0);
    check(data_busy_n === 1'b1, "R3", "still idle", int'(data_busy_n), 1);
    wr_reg(2, 1);
    d0 = done_cnt;
    arm(20, 2);
    wait_idle();
    end_xfer(d0, "R3 kept counters");

    // R10 pause and resume
    wr_reg(3, 3);
    rdy_mode = 0; rdy_hold = 1;
    d0 = done_cnt;
    setup_xfer(30, 9);
    arm(30, 9);
    repeat (20) @(posedge clk);
    #1;
    rdy_hold = 0;
    repeat (3) @(posedge clk);
    #1;
    wr_reg(2, 0);
    repeat (10) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R10", "paused valid", int'(out_valid), 0);
    check(data_busy_n === 1'b1, "R10", "paused busy_n", int'(data_busy_n), 1);
    check(done_cnt == d0, "R10", "no done on pause", done_cnt, d0);
    check(exp_q.size() > 0, "R10", "bytes left at pause", exp_q.size(), 1);
    wr_reg(2, 1);
    rdy_hold = 1;
    fire(1'b1);
    wait_idle();
    end_xfer(d0, "R10 resume");
    rdy_mode = 1;

    // R7 count zero moves one byte; R6 top address
    wr_reg(3, 1);
    d0 = done_cnt;
    setup_xfer(63, 0);
    arm(63, 0);
    wait_idle();
    end_xfer(d0, "single byte");

    finish_run();
  end

endmodule